// File: doc/BRIEF.md
# Paged Memory Mapper with Fixed Top

This block translates the 16-bit logical addresses of a small CPU into physical RAM block numbers. The logical space is cut into eight 8 KB windows. While translation is on, each window is looked up in one of two task maps, picked by a task bit, and the lookup yields a 7-bit physical block number plus a write-protect flag. While translation is off, every window maps to the physical block with its own number. The block also drives the ROM select for the top 8 KB of the space, flags accesses to a 16-byte I/O window, and gates the memory write enable.

Software programs the block through two write-only registers inside the I/O window. The control register carries a ROM-disable bit, the task bit, the enable bit and a 4-bit entry pointer. The data register writes a block number and protect flag into the entry that pointer names. One write pattern to the control register, meaningless in any other state, arms a mode that pins the top 512 bytes of the space (except the I/O window) to physical block 7. A control write that turns translation off disarms it again.

Top module: `page_mapper`

## Requirements
- R1: After reset, ROM-disable, translation enable and the fixed-top flag are all 0: every window maps to its own number, write protect is 0, and non-write accesses in 0xE000-0xFFFF outside the I/O window assert rom_sel.
- R2: With translation off, an access to window n (address bits 15:13) outputs physical block n and wr_prot 0, whatever the map holds.
- R3: A write to 0xFFDE loads the control register (bit 7 ROM-disable, bit 6 task, bit 5 enable, bit 4 arm guard, bits 3:0 entry pointer); a write to 0xFFDF stores bit 7 as the protect flag and bits 6:0 as the block number of the entry the pointer names, in either translation state.
- R4: With translation on, the entry used is task × 8 + address bits 15:13, and its block number and protect flag appear on phys_blk and wr_prot.
- R5: Accesses to 0xFFD0-0xFFDF assert io_sel and never assert mem_we, rom_sel or wr_prot.
- R6: A control write with bit 5 = 0 turns translation off, clears the fixed-top flag and loads ROM-disable from bit 7.
- R7: When ROM-disable and enable are both 1, a control write with bit 7 = 0, bit 5 = 1 and bit 4 = 0 sets the fixed-top flag and leaves ROM-disable and enable at 1.
- R8: Any other control write with bit 5 = 1 loads ROM-disable from bit 7, sets enable, and leaves the fixed-top flag as it was.
- R9: With the fixed-top flag set, accesses in 0xFE00-0xFFFF outside the I/O window map to block 7 with wr_prot 0 and rom_sel 0, for either task and any map contents.
- R10: rom_sel is 1 for a non-write access in 0xE000-0xFFFF while ROM-disable is 0, outside the I/O window and outside the fixed top; otherwise 0.
- R11: mem_we equals cpu_wr except that it is 0 in the I/O window and whenever wr_prot is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data, used for register writes |
| phys_blk | output | 7 | Physical RAM block number of the current access |
| rom_sel | output | 1 | Selects ROM instead of RAM |
| wr_prot | output | 1 | Current access falls in a write-protected block |
| io_sel | output | 1 | Current access falls in the I/O window |
| mem_we | output | 1 | Memory write enable after protection and I/O gating |

## Verification
The bench builds the block with its default parameters: a 16-bit address, eight windows, two tasks, 7-bit block numbers, the I/O window at 0xFFD0 and the 512-byte fixed top. With only sixteen map entries, it fills every entry with an arithmetic pattern and then sweeps the whole address space in 256-byte steps, plus the edges of the I/O window, the fixed top and the ROM window, for both reads and writes, after each control state it drives. That covers both tasks, translation on and off, ROM enabled and disabled, and arming, keeping and clearing the fixed top, all compared against a model in the bench.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;

   // control register bit positions (the arming pattern decodes these)
   localparam int CTL_ROM_DIS = 7;
   localparam int CTL_TASK    = 6;
   localparam int CTL_ENABLE  = 5;
   localparam int CTL_GUARD   = 4;
   // data register protect bit
   localparam int DAT_PROT    = 7;

   typedef struct packed {
      logic rom_dis;
      logic map_en;
      logic fix_top;
   } mapper_mode_t;

   // next mode after a control write
   function automatic mapper_mode_t next_mode(input mapper_mode_t cur,
                                              input logic [7:0] wd);
      mapper_mode_t n;
      n = cur;
      if (!wd[CTL_ENABLE]) begin
         n.rom_dis = wd[CTL_ROM_DIS];
         n.map_en  = 1'b0;
         n.fix_top = 1'b0;
      end else if (cur.rom_dis && cur.map_en &&
                   !wd[CTL_ROM_DIS] && !wd[CTL_GUARD]) begin
         n.fix_top = 1'b1;
      end else begin
         n.rom_dis = wd[CTL_ROM_DIS];
         n.map_en  = 1'b1;
      end
      return n;
   endfunction

endpackage

// File: rtl/page_mapper_ctl.sv
module page_mapper_ctl
   import page_mapper_pkg::*;
#(
   parameter int TASK_W = 1,
   parameter int ENT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [7:0]        wdata,
   output mapper_mode_t      mode,
   output logic [TASK_W-1:0] task_sel,
   output logic [ENT_W-1:0]  ent_ptr
);

   localparam int PTR_TOP = ENT_W - 1;

   if (TASK_W != 1) begin : g_bad_task
      $error("page_mapper_ctl: the control register holds a single task bit");
   end
   if (ENT_W > 4) begin : g_bad_ptr
      $error("page_mapper_ctl: entry pointer is limited to four bits");
   end

   mapper_mode_t mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= '0;
         task_sel <= '0;
         ent_ptr  <= '0;
      end else if (ctl_we) begin
         mode_q   <= next_mode(mode_q, wdata);
         task_sel <= wdata[CTL_TASK];
         ent_ptr  <= wdata[PTR_TOP:0];
      end
   end

   assign mode = mode_q;

endmodule

// File: rtl/page_mapper_tbl.sv
module page_mapper_tbl
   import page_mapper_pkg::*;
#(
   parameter int ENT_W  = 4,
   parameter int PHYS_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_we,
   input  logic [ENT_W-1:0]  wr_ptr,
   input  logic [7:0]        wdata,
   input  logic [ENT_W-1:0]  rd_idx,
   output logic [PHYS_W-1:0] rd_blk,
   output logic              rd_prot
);

   localparam int ENTRIES = 1 << ENT_W;

   if (PHYS_W > DAT_PROT) begin : g_bad_phys
      $error("page_mapper_tbl: block number must fit below the protect bit");
   end

   logic [PHYS_W-1:0] blk_q  [ENTRIES];
   logic              prot_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            blk_q[e]  <= '0;
            prot_q[e] <= 1'b0;
         end else if (dat_we && (wr_ptr == ENT_W'(e))) begin
            blk_q[e]  <= wdata[PHYS_W-1:0];
            prot_q[e] <= wdata[DAT_PROT];
         end
      end
   end

   assign rd_blk  = blk_q[rd_idx];
   assign rd_prot = prot_q[rd_idx];

endmodule

// File: rtl/page_mapper_xlat.sv
module page_mapper_xlat
   import page_mapper_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_W     = 3,
   parameter int TASK_W    = 1,
   parameter int PHYS_W    = 7,
   parameter int IO_BASE   = 'hFFD0,
   parameter int IO_SIZE   = 16,
   parameter int ROM_BYTES = 8192,
   parameter bit FIX_EN    = 1'b1,
   parameter int FIX_BYTES = 512,
   parameter int FIX_BLK   = 7
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    cpu_wr,
   input  mapper_mode_t            mode,
   input  logic [TASK_W-1:0]       task_sel,
   input  logic [PHYS_W-1:0]       ent_blk,
   input  logic                    ent_prot,
   output logic [TASK_W+WIN_W-1:0] ent_idx,
   output logic [PHYS_W-1:0]       phys_blk,
   output logic                    rom_sel,
   output logic                    wr_prot,
   output logic                    io_sel,
   output logic                    mem_we
);

   localparam int WIN_LSB = ADDR_W - WIN_W;
   localparam logic [ADDR_W-1:0] IO_LO  = ADDR_W'(IO_BASE);
   localparam logic [ADDR_W-1:0] IO_HI  = ADDR_W'(IO_BASE + IO_SIZE - 1);
   localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'((1 << ADDR_W) - ROM_BYTES);
   localparam logic [ADDR_W-1:0] FIX_LO = ADDR_W'((1 << ADDR_W) - FIX_BYTES);

   if (PHYS_W < WIN_W) begin : g_bad_width
      $error("page_mapper_xlat: block number narrower than window index");
   end
   if (FIX_BLK >= (1 << PHYS_W)) begin : g_bad_fix
      $error("page_mapper_xlat: fixed block out of range");
   end

   logic [WIN_W-1:0] win;
   logic             io_hit;
   logic             rom_hit;
   logic             fix_hit;

   assign win     = addr[ADDR_W-1:WIN_LSB];
   assign io_hit  = (addr >= IO_LO) && (addr <= IO_HI);
   assign rom_hit = addr >= ROM_LO;
   assign ent_idx = {task_sel, win};

   if (FIX_EN) begin : g_fix
      assign fix_hit = mode.fix_top && (addr >= FIX_LO) && !io_hit;
   end else begin : g_nofix
      logic unused_fix;
      assign unused_fix = mode.fix_top;
      assign fix_hit    = 1'b0;
   end

   always_comb begin
      if (fix_hit) begin
         phys_blk = PHYS_W'(FIX_BLK);
         wr_prot  = 1'b0;
      end else if (mode.map_en) begin
         phys_blk = ent_blk;
         wr_prot  = ent_prot && !io_hit;
      end else begin
         phys_blk = PHYS_W'(win);
         wr_prot  = 1'b0;
      end
      io_sel  = io_hit;
      rom_sel = !mode.rom_dis && rom_hit && !io_hit && !fix_hit && !cpu_wr;
      mem_we  = cpu_wr && !io_hit && !wr_prot;
   end

endmodule

// File: rtl/page_mapper.sv
module page_mapper
   import page_mapper_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_W     = 3,
   parameter int TASK_W    = 1,
   parameter int PHYS_W    = 7,
   parameter int IO_BASE   = 'hFFD0,
   parameter int IO_SIZE   = 16,
   parameter int CTL_OFS   = 14,
   parameter int DAT_OFS   = 15,
   parameter int ROM_BYTES = 8192,
   parameter bit FIX_EN    = 1'b1,
   parameter int FIX_BYTES = 512,
   parameter int FIX_BLK   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic [7:0]        cpu_wdata,
   output logic [PHYS_W-1:0] phys_blk,
   output logic              rom_sel,
   output logic              wr_prot,
   output logic              io_sel,
   output logic              mem_we
);

   localparam int ENT_W = TASK_W + WIN_W;
   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(IO_BASE + CTL_OFS);
   localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(IO_BASE + DAT_OFS);

   if (CTL_OFS >= IO_SIZE || DAT_OFS >= IO_SIZE || CTL_OFS == DAT_OFS) begin : g_bad_regs
      $error("page_mapper: register offsets must be distinct and inside the I/O window");
   end
   if (FIX_BYTES > ROM_BYTES) begin : g_bad_span
      $error("page_mapper: fixed top must lie inside the top window");
   end

   logic              ctl_we;
   logic              dat_we;
   mapper_mode_t      mode;
   logic [TASK_W-1:0] task_sel;
   logic [ENT_W-1:0]  ent_ptr;
   logic [ENT_W-1:0]  ent_idx;
   logic [PHYS_W-1:0] ent_blk;
   logic              ent_prot;

   assign ctl_we = cpu_wr && (cpu_addr == CTL_ADDR);
   assign dat_we = cpu_wr && (cpu_addr == DAT_ADDR);

   page_mapper_ctl #(
      .TASK_W (TASK_W),
      .ENT_W  (ENT_W)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .wdata    (cpu_wdata),
      .mode     (mode),
      .task_sel (task_sel),
      .ent_ptr  (ent_ptr)
   );

   page_mapper_tbl #(
      .ENT_W  (ENT_W),
      .PHYS_W (PHYS_W)
   ) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .dat_we  (dat_we),
      .wr_ptr  (ent_ptr),
      .wdata   (cpu_wdata),
      .rd_idx  (ent_idx),
      .rd_blk  (ent_blk),
      .rd_prot (ent_prot)
   );

   page_mapper_xlat #(
      .ADDR_W    (ADDR_W),
      .WIN_W     (WIN_W),
      .TASK_W    (TASK_W),
      .PHYS_W    (PHYS_W),
      .IO_BASE   (IO_BASE),
      .IO_SIZE   (IO_SIZE),
      .ROM_BYTES (ROM_BYTES),
      .FIX_EN    (FIX_EN),
      .FIX_BYTES (FIX_BYTES),
      .FIX_BLK   (FIX_BLK)
   ) u_xlat (
      .addr     (cpu_addr),
      .cpu_wr   (cpu_wr),
      .mode     (mode),
      .task_sel (task_sel),
      .ent_blk  (ent_blk),
      .ent_prot (ent_prot),
      .ent_idx  (ent_idx),
      .phys_blk (phys_blk),
      .rom_sel  (rom_sel),
      .wr_prot  (wr_prot),
      .io_sel   (io_sel),
      .mem_we   (mem_we)
   );

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
   parameter int ADDR_W = 16,
   parameter int PHYS_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_wr,
   input logic [7:0]        cpu_wdata,
   input logic              ctl_we,
   input logic              rom_dis,
   input logic              map_en,
   input logic              fix_top,
   input logic [PHYS_W-1:0] phys_blk,
   input logic              rom_sel,
   input logic              wr_prot,
   input logic              io_sel,
   input logic              mem_we
);

   a_r5_io_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel |-> (!mem_we && !rom_sel && !wr_prot));

   a_r11_protect_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && wr_prot) |-> !mem_we);

   a_r6_disable_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !cpu_wdata[5]) |=> (!fix_top && !map_en));

   a_r7_arm_top: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && rom_dis && map_en && !cpu_wdata[7] && cpu_wdata[5] && !cpu_wdata[4])
      |=> (fix_top && rom_dis && map_en));

   a_r9_top_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_top && (cpu_addr >= ADDR_W'('hFE00)) && !io_sel)
      |-> (phys_blk == PHYS_W'(7) && !wr_prot && !rom_sel));

   a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (!map_en && !fix_top) |-> (phys_blk == PHYS_W'(cpu_addr[ADDR_W-1:ADDR_W-3])));

   a_r8_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && cpu_wdata[5]) |=> (fix_top == $past(fix_top) || fix_top));

endmodule

bind page_mapper page_mapper_chk #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_wr    (cpu_wr),
   .cpu_wdata (cpu_wdata),
   .ctl_we    (ctl_we),
   .rom_dis   (mode.rom_dis),
   .map_en    (mode.map_en),
   .fix_top   (mode.fix_top),
   .phys_blk  (phys_blk),
   .rom_sel   (rom_sel),
   .wr_prot   (wr_prot),
   .io_sel    (io_sel),
   .mem_we    (mem_we)
);

// File: tb/page_mapper_test.sv
module page_mapper_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [6:0]  phys_blk;
   logic        rom_sel, wr_prot, io_sel, mem_we;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of the programmed state
   bit       m_rom_dis, m_en, m_fix, m_task;
   bit [3:0] m_ptr;
   bit [7:0] m_map [16];

   always #10 clk = ~clk;

   page_mapper uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .phys_blk  (phys_blk),
      .rom_sel   (rom_sel),
      .wr_prot   (wr_prot),
      .io_sel    (io_sel),
      .mem_we    (mem_we)
   );

   task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp,
                        input logic [15:0] a);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, act, exp);
      end
   endtask

   // register write through the CPU port, applied to the model too
   task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      if (a == 16'hFFDE) begin
         m_task = d[6]; m_ptr = d[3:0];
         if (!d[5]) begin m_rom_dis = d[7]; m_en = 0; m_fix = 0; end
         else if (m_rom_dis && m_en && !d[7] && !d[4]) m_fix = 1;
         else begin m_rom_dis = d[7]; m_en = 1; end
      end else if (a == 16'hFFDF) begin
         m_map[m_ptr] = d;
      end
   endtask

   task automatic probe(input string tag, input logic [15:0] a, input bit w);
      bit io, fix, wp, rom, we;
      logic [6:0] blk;
      logic [10:0] exp, act;
      @(negedge clk);
      cpu_addr = a; cpu_wr = w;
      #2;
      io  = (a >= 16'hFFD0) && (a <= 16'hFFDF);
      fix = m_fix && (a >= 16'hFE00) && !io;
      if (fix) begin blk = 7; wp = 0; end
      else if (m_en) begin
         blk = m_map[{m_task, a[15:13]}][6:0];
         wp  = m_map[{m_task, a[15:13]}][7] && !io;
      end else begin blk = 7'(a[15:13]); wp = 0; end
      rom = !m_rom_dis && (a >= 16'hE000) && !io && !fix && !w;
      we  = w && !io && !wp;
      exp = {io ? 7'd0 : blk, wp, rom, io, we};
      act = {io ? 7'd0 : phys_blk, wr_prot, rom_sel, io_sel, mem_we};
      check(tag, act, exp, a);
      #2;
      cpu_wr = 1'b0;
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < 256; i++) begin
         probe(tag, 16'(i * 256 + 16), 1'b0);
         probe(tag, 16'(i * 256 + 32), 1'b1);
      end
      foreach (edge_addrs[k]) begin
         probe(tag, edge_addrs[k], 1'b0);
         if (edge_addrs[k] != 16'hFFDE && edge_addrs[k] != 16'hFFDF)
            probe(tag, edge_addrs[k], 1'b1);
      end
   endtask

   logic [15:0] edge_addrs [10] = '{16'hDFFF, 16'hE000, 16'hFDFF, 16'hFE00,
                                    16'hFFCF, 16'hFFD0, 16'hFFDF, 16'hFFE0,
                                    16'hFFFF, 16'h0000};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      sweep("R1");
      // R3: program every entry while translation is off
      for (int i = 0; i < 16; i++) begin
         wr_reg(16'hFFDE, 8'(i));
         wr_reg(16'hFFDF, {(i % 3 == 0) ? 1'b1 : 1'b0, 7'((i * 37 + 5) % 128)});
      end
      sweep("R2");                     // map ignored while off
      wr_reg(16'hFFDE, 8'hA0); sweep("R4");   // task 0, ROM off
      wr_reg(16'hFFDE, 8'hE0); sweep("R11");  // task 1, protected windows
      wr_reg(16'hFFDE, 8'h20); sweep("R7");   // arm fixed top
      wr_reg(16'hFFDE, 8'h60); sweep("R9");   // task 1 with fixed top
      wr_reg(16'hFFDE, 8'h30); sweep("R10");  // ROM back on, top kept
      wr_reg(16'hFFDE, 8'hB0); sweep("R8");
      wr_reg(16'hFFDE, 8'h80); sweep("R6");   // off, top cleared
      wr_reg(16'hFFDE, 8'h20); sweep("R8");   // no arm without prior enable
      // R3: rewrite one entry with translation on and observe it
      wr_reg(16'hFFDE, 8'hA2);
      wr_reg(16'hFFDF, 8'h55);
      sweep("R3");
      // R5: I/O window sweep
      for (int a = 16'hFFC8; a <= 16'hFFE8; a++) probe("R5", 16'(a), 1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule